// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a parallel data word into a serial stream of fixed-length frames. Each frame is two bits longer than the word. A leading 1 and a trailing 0 surround the payload, so every frame has at least one rising edge that a receiver can use to recover the word clock. The block runs on a clock at the bit rate. A word-strobe input, pulsed once every frame length, marks where each frame starts, so no PLL is modelled. A frame is loaded on the clock edge where the strobe is high. It appears on the serial output one bit per clock, starting on the next cycle.

For link training, either of two sync request inputs replaces the data frames with a sync frame. The sync frame is a run of ones filling its first half and a run of zeros filling its second half. Once a request is seen, the block sends a minimum burst of sync frames even if the request is withdrawn at once.

An output enable and a powerdown input control a drive-valid flag, which stands in for a high-impedance pad. After powerdown is released, and after reset, the block counts a fixed number of word strobes as initialization and keeps the output undriven during that time.

Top module: `ser_frame_tx`

## Requirements
- R1: A data frame is FRAME_W = DATA_W+2 bits, sent one bit per clock starting the cycle after the strobe edge: first a 1, then data bits 0 to DATA_W-1 in ascending order, then a 0. The data word is captured on the strobe edge.
- R2: A sync frame sends FRAME_W/2 ones followed by FRAME_W/2 zeros, in the same slot a data frame would use.
- R3: The two sync request inputs are ORed. A strobe edge where either is high loads a sync frame.
- R4: A request seen on one strobe edge yields at least MIN_SYNC consecutive sync frames, even if the request drops after that edge.
- R5: While a request stays high, sync frames continue without a gap. Data frames resume at the first strobe edge where the request is low and the minimum burst has been served.
- R6: The data inputs have no effect on any frame loaded as a sync frame.
- R7: When the enable is low or powerdown is high, drive_o is 0 and ser_o is 0, in the same cycle and without waiting for a clock edge.
- R8: After reset or after powerdown is released, drive_o stays 0 until INIT_WORDS strobe edges have been taken. The frame loaded at the INIT_WORDS-th strobe edge is the first one driven.
- R9: Powerdown discards any burst in progress and clears the frame in flight. After the new initialization, no leftover sync frames are sent.
- R10: A new request that arrives after a burst has ended starts a fresh burst of at least MIN_SYNC sync frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| stb_i | input | 1 | Word strobe, one cycle high per frame slot |
| data_i | input | DATA_W | Parallel data word |
| sync_a_i | input | 1 | Sync request, first source |
| sync_b_i | input | 1 | Sync request, second source |
| en_i | input | 1 | Output enable |
| pd_i | input | 1 | Powerdown, active high |
| ser_o | output | 1 | Serial bit, 0 when not driven |
| drive_o | output | 1 | Output is actively driven |

## Verification
The bench builds the block with a 10-bit word and reduces both counters: MIN_SYNC to 5 and INIT_WORDS to 3. With these values, the end of a minimum burst, a counter reload while a request is held, and a full re-initialization after powerdown each take only a few frames, so the bench can reach every one of them. At each edge, a queue-based reference predicts every serial bit. Frames decoded from the output pins are counted, and those counts confirm the burst lengths and the number of strobes before the output is driven again.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
   typedef enum logic [1:0] {
      FK_IDLE = 2'd0,
      FK_DATA = 2'd1,
      FK_SYNC = 2'd2
   } frame_kind_e;
endpackage

// File: rtl/ser_init_ctrl.sv
module ser_init_ctrl #(
   parameter int INIT_WORDS = 1024
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pd_i,
   input  logic stb_i,
   output logic ready_o,
   output logic load_ok_o
);
   localparam int IW = (INIT_WORDS > 1) ? $clog2(INIT_WORDS) : 1;
   localparam logic [IW-1:0] LAST = IW'(INIT_WORDS - 1);

   logic [IW-1:0] cnt_q;
   logic          ready_q;
   logic          last_w;

   assign last_w    = !ready_q && (cnt_q == LAST);
   assign load_ok_o = ready_q || last_w;
   assign ready_o   = ready_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || pd_i) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (stb_i && !ready_q) begin
         if (last_w) ready_q <= 1'b1;
         else        cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ser_sync_ctrl.sv
module ser_sync_ctrl #(
   parameter int MIN_SYNC = 1024
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pd_i,
   input  logic adv_i,
   input  logic req_i,
   output logic send_sync_o,
   output logic busy_o
);
   generate
      if (MIN_SYNC == 1) begin : g_nocnt
         assign send_sync_o = req_i;
         assign busy_o      = 1'b0;
      end else begin : g_cnt
         localparam int CW = $clog2(MIN_SYNC);
         localparam logic [CW-1:0] RELOAD = CW'(MIN_SYNC - 1);
         logic [CW-1:0] left_q;

         assign busy_o      = (left_q != '0);
         assign send_sync_o = req_i || busy_o;

         always_ff @(posedge clk_i) begin
            if (!rst_ni || pd_i) begin
               left_q <= '0;
            end else if (adv_i) begin
               if (busy_o)     left_q <= left_q - 1'b1;
               else if (req_i) left_q <= RELOAD;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift #(
   parameter int FRAME_W = 12
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clr_i,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic [FRAME_W-1:0] sh_o
);
   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) sh_q <= '0;
      else if (load_i)      sh_q <= frame_i;
      else                  sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
   end

   assign sh_o = sh_q;
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
   import ser_frame_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int MIN_SYNC   = 1024,
   parameter int INIT_WORDS = 1024
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              stb_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              sync_a_i,
   input  logic              sync_b_i,
   input  logic              en_i,
   input  logic              pd_i,
   output logic              ser_o,
   output logic              drive_o
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int HALF    = FRAME_W / 2;

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 2");
      end
      if (MIN_SYNC < 1) begin : g_bad_sync
         $error("MIN_SYNC must be at least 1");
      end
      if (INIT_WORDS < 1) begin : g_bad_init
         $error("INIT_WORDS must be at least 1");
      end
   endgenerate

   logic [FRAME_W-1:0] sync_pat;
   generate
      for (genvar b = 0; b < FRAME_W; b++) begin : g_pat
         assign sync_pat[b] = (b < HALF);
      end
   endgenerate

   logic               ready_q, load_ok, busy_q, send_sync, req;
   logic [FRAME_W-1:0] sh_q, next_frame;
   frame_kind_e        kind;

   assign req = sync_a_i | sync_b_i;

   ser_init_ctrl #(.INIT_WORDS(INIT_WORDS)) u_init (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pd_i     (pd_i),
      .stb_i    (stb_i),
      .ready_o  (ready_q),
      .load_ok_o(load_ok)
   );

   ser_sync_ctrl #(.MIN_SYNC(MIN_SYNC)) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pd_i       (pd_i),
      .adv_i      (stb_i && load_ok),
      .req_i      (req),
      .send_sync_o(send_sync),
      .busy_o     (busy_q)
   );

   always_comb begin
      if (!load_ok)       kind = FK_IDLE;
      else if (send_sync) kind = FK_SYNC;
      else                kind = FK_DATA;
      unique case (kind)
         FK_SYNC: next_frame = sync_pat;
         FK_DATA: next_frame = {1'b0, data_i, 1'b1};
         default: next_frame = '0;
      endcase
   end

   ser_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (pd_i),
      .load_i (stb_i),
      .frame_i(next_frame),
      .sh_o   (sh_q)
   );

   assign drive_o = en_i && !pd_i && ready_q;
   assign ser_o   = drive_o && sh_q[0];
endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk #(
   parameter int DATA_W = 10
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              stb_i,
   input logic [DATA_W-1:0] data_i,
   input logic              sync_a_i,
   input logic              sync_b_i,
   input logic              en_i,
   input logic              pd_i,
   input logic              ser_o,
   input logic              drive_o,
   input logic [DATA_W+1:0] sh_q,
   input logic              ready_q,
   input logic              busy_q
);
   localparam int FW = DATA_W + 2;
   logic [FW-1:0] pat;
   always_comb for (int i = 0; i < FW; i++) pat[i] = (i < FW / 2);

   // R1
   data_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && !pd_i && ready_q && !sync_a_i && !sync_b_i && !busy_q)
      |=> (sh_q[0] && !sh_q[FW-1] && sh_q[FW-2:1] == $past(data_i)));

   // R1
   shift_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stb_i && !pd_i) |=> (sh_q[FW-2:0] == $past(sh_q[FW-1:1])));

   // R3
   sync_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && !pd_i && ready_q && (sync_a_i || sync_b_i)) |=> (sh_q == pat));

   // R4
   burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && !pd_i && busy_q) |=> (sh_q == pat));

   // R7
   quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i || pd_i) |-> (!ser_o && !drive_o));

   // R8
   wake_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(pd_i) |-> !drive_o);
endmodule

bind ser_frame_tx ser_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .stb_i   (stb_i),
   .data_i  (data_i),
   .sync_a_i(sync_a_i),
   .sync_b_i(sync_b_i),
   .en_i    (en_i),
   .pd_i    (pd_i),
   .ser_o   (ser_o),
   .drive_o (drive_o),
   .sh_q    (sh_q),
   .ready_q (ready_q),
   .busy_q  (busy_q)
);

// File: tb/ser_frame_tx_bench.sv
`timescale 1ns/1ps
module ser_frame_tx_bench;
   localparam int DW   = 10;
   localparam int FW   = DW + 2;
   localparam int MINS = 5;
   localparam int INIT = 3;

   logic clk = 0, rst_n = 0, stb = 0, sa = 0, sb = 0, en = 0, pd = 0;
   logic [DW-1:0] dat = 10'h2A5;
   logic ser, drv;

   always #2.5 clk = ~clk;

   ser_frame_tx #(.DATA_W(DW), .MIN_SYNC(MINS), .INIT_WORDS(INIT)) u_ser_frame_tx (
      .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .data_i(dat), .sync_a_i(sa),
      .sync_b_i(sb), .en_i(en), .pd_i(pd), .ser_o(ser), .drive_o(drv));

   int checks = 0, errors = 0;
   string cur_req = "R8";

   // reference model state
   bit m_q[$];
   bit m_ready = 0;
   int m_init = 0, m_left = 0, m_pos = 99;
   bit [FW-1:0] cap, sync_pat;
   int sync_seen = 0, data_seen = 0;
   bit waiting = 1;
   int wake_stb = 0;

   initial for (int i = 0; i < FW; i++) sync_pat[i] = (i < FW / 2);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n || pd) begin
         m_q = {}; m_ready = 0; m_init = 0; m_left = 0; m_pos = 99;
         waiting = 1; wake_stb = 0;
      end else if (stb) begin
         bit lok;
         lok = m_ready || (m_init == INIT - 1);
         if (!m_ready) m_init++;
         m_q = {};
         if (lok) begin
            m_ready = 1;
            if (sa || sb || m_left > 0) begin
               for (int i = 0; i < FW; i++) m_q.push_back(i < FW / 2);
               if (m_left > 0) m_left--; else m_left = MINS - 1;
            end else begin
               m_q.push_back(1);
               for (int i = 0; i < DW; i++) m_q.push_back(dat[i]);
               m_q.push_back(0);
            end
         end else begin
            for (int i = 0; i < FW; i++) m_q.push_back(0);
         end
         m_pos = 0;
         if (waiting) wake_stb++;
      end else begin
         if (m_q.size() > 0) void'(m_q.pop_front());
         m_pos++;
      end
      #1;
      begin
         bit e_drv, e_ser;
         e_drv = en && !pd && m_ready;
         e_ser = e_drv && (m_q.size() > 0 ? m_q[0] : 1'b0);
         chk(drv === e_drv, {cur_req, " drive"}, drv, e_drv);
         chk(ser === e_ser, {cur_req, " serial"}, ser, e_ser);
         if (waiting && drv) begin
            chk(wake_stb == INIT, "R8 strobes before drive", wake_stb, INIT);
            waiting = 0;
         end
         if (m_pos < FW) begin
            cap[m_pos] = ser;
            if (m_pos == FW - 1 && drv) begin
               if (cap == sync_pat) sync_seen++; else data_seen++;
            end
         end
      end
   end

   int ph = 0;
   task automatic tick();
      @(negedge clk);
      stb = (ph == 0);
      ph = (ph + 1) % FW;
      dat = {dat[DW-2:0], dat[DW-1] ^ dat[6]} ^ DW'(ph);
   endtask

   task automatic frames(input int n);
      repeat (n * FW) tick();
   endtask

   task automatic align();
      while (ph != 0) tick();
   endtask

   task automatic pulse_b();
      align();
      sb = 1; tick(); tick(); sb = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(drv === 1'b0 && ser === 1'b0, "R8 reset state", drv, 0);
      en = 1; rst_n = 1;
      cur_req = "R8"; frames(INIT + 1);
      cur_req = "R1"; data_seen = 0; frames(5);
      chk(data_seen >= 4, "R1 data frames seen", data_seen, 4);

      cur_req = "R4"; sync_seen = 0; pulse_b(); frames(MINS + 3);
      chk(sync_seen == MINS, "R4 burst length", sync_seen, MINS);
      chk(sync_seen > 0, "R2 sync pattern decoded", sync_seen, MINS);

      cur_req = "R10"; sync_seen = 0; pulse_b(); frames(MINS + 3);
      chk(sync_seen == MINS, "R10 fresh burst", sync_seen, MINS);

      cur_req = "R5"; sync_seen = 0; align(); sa = 1; frames(8); sa = 0;
      cur_req = "R6"; frames(MINS + 3);
      chk(sync_seen >= 8, "R5 held request", sync_seen, 8);

      cur_req = "R3"; sync_seen = 0; align(); sa = 1; sb = 1; tick(); tick();
      sa = 0; frames(MINS + 2); sb = 0; frames(MINS + 2);
      chk(sync_seen >= MINS, "R3 ORed request", sync_seen, MINS);

      cur_req = "R7"; en = 0; frames(2); repeat (5) tick(); en = 1; frames(2);
      tick(); pd = 1; repeat (3) tick(); pd = 0;

      cur_req = "R9"; frames(INIT + 2);
      pulse_b(); frames(2); pd = 1; repeat (30) tick(); pd = 0;
      sync_seen = 0; frames(INIT + 6);
      chk(sync_seen == 0, "R9 burst dropped by powerdown", sync_seen, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule